// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits on the host side of an asynchronous byte-wide EPROM and turns a single-cycle read request into a timed strobe sequence. On a request it places the address on the memory bus, lowers the active-low chip select, and waits a set number of clocks. It then lowers the active-low output gate, waits a second set number of clocks, and registers the data lines. It returns the byte with a one-cycle acknowledge. Both strobes go high together for one cycle before the bus is used again. The two waits are parameters in clock cycles. The first covers the access time less the output-gate delay, and the second covers the output-gate delay.

An identify request reads two identifier bytes in a row. The first is read at address 0 and is the manufacturer code. The second is read at address 1 and is the device code. Every other address bit stays low for both reads. The block does not generate the high-voltage identify level. It only raises a mode-request output for the whole two-read sequence so that external circuitry can apply that level. Each identifier byte must contain an odd number of ones, with bit 7 serving as the parity bit. A byte with an even count is returned with an error flag.

Top module: `eprom_reader`

## Requirements
- R1: After a synchronous reset, `mem_ce_n` and `mem_oe_n` are 1, `ack` is 0, `mem_addr` is 0 and `id_mode_req` is 0.
- R2: `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R3: When a request is accepted in idle, `mem_ce_n` falls one cycle later. `mem_oe_n` falls exactly `T_CE_OE` cycles after `mem_ce_n` falls.
- R4: The data lines are registered exactly `T_OE` cycles after `mem_oe_n` falls. In the next cycle `ack` is 1 for one cycle, with `data` holding that byte. `ack` is therefore high `2+T_CE_OE+T_OE` cycles after the accepting edge, counting that edge's cycle as 0.
- R5: For a normal read, `mem_addr` equals the requested `addr` and does not change while `mem_ce_n` is 0.
- R6: In the cycle after each `ack`, both strobes are 1. A new access cannot lower `mem_ce_n` until at least one more cycle has passed.
- R7: A `req` seen while an access is in progress is ignored. No extra access and no extra `ack` follow from it.
- R8: A request with `id_mode`=1 performs two reads, at `mem_addr` 0 and then at `mem_addr` 1, with every bit above bit 0 at 0. It returns two `ack` pulses, the manufacturer byte first and the device byte second. `id_mode_req` stays 1 from the cycle after acceptance until the cycle after the second `ack`.
- R9: With each `ack` of an identify read, `parity_err` is 1 if the byte has an even number of ones and 0 if it has an odd number. On normal reads it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, sampled only in idle |
| addr | input | ADDR_W | Byte address for a normal read |
| id_mode | input | 1 | With req: perform the two-byte identifier read |
| ack | output | 1 | One-cycle pulse: `data` and `parity_err` are valid |
| data | output | DATA_W | Captured byte |
| parity_err | output | 1 | Identifier byte had even parity |
| id_mode_req | output | 1 | Request to external circuitry to apply the identify level |
| mem_addr | output | ADDR_W | Address bus to the EPROM |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output gate |
| mem_dq | input | DATA_W | Data lines from the EPROM |

## Verification
The embedded properties assume that `T_CE_OE` and `T_OE` are both at least 1. They also assume that the host leaves `req` low for at least one cycle after an `ack` unless it wants a new access, because any `req` seen in idle starts one. The bench drives `req` as a one-cycle pulse and waits for the last `ack` and the release cycle before it issues the next pulse. The busy-time pulse is placed deliberately in the middle of an access.

The bench's memory model drives a wrong byte unless select has been low for `T_CE_OE+T_OE-1` prior edges and the gate for `T_OE-1` prior edges. As a result, a capture that happens early, or with a strobe high, returns a value that fails the data check.

// File: rtl/eprom_rd_pkg.sv
// Package: shared types for the EPROM read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package eprom_rd_pkg;

    // Access phases; strobe levels are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_CE_WAIT = 3'd2,
        ST_OE_WAIT = 3'd3,
        ST_CAPTURE = 3'd4,
        ST_RELEASE = 3'd5
    } rd_state_t;

endpackage

// File: rtl/eprom_wait_timer.sv
// Module: reloadable down-counter used for both strobe waits.
// A load writes load_val; the count then falls by one per cycle to zero.
// expired is high while the count is zero. Holding load_val = N-1 makes
// a wait of exactly N cycles after the load edge.
// Assumes: load is not asserted in a cycle where expiry is being consumed
// unless a new wait is intended.
module eprom_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on request, otherwise decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag is a pure decode of the count.
    assign expired = (cnt_q == '0);

    // R3: a running count only ever moves down by one
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eprom_id_parity.sv
// Module: odd-parity check for an identifier byte.
// Purely combinational; odd_ok is high when the byte has an odd number
// of set bits (the top bit is the parity bit).
// Assumes: DATA_W >= 2.
module eprom_id_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_in,
    output logic              odd_ok
);

    logic [DATA_W-1:0] fold;

    // Ripple XOR chain over the byte, one stage per bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_fold
        if (g == 0) begin : g_first
            assign fold[g] = byte_in[g];
        end else begin : g_next
            assign fold[g] = fold[g-1] ^ byte_in[g];
        end
    end

    assign odd_ok = fold[DATA_W-1];

endmodule

// File: rtl/eprom_rd_seq.sv
// Module: phase sequencer for one or two EPROM reads.
// Moves IDLE -> SETUP -> CE_WAIT -> OE_WAIT -> CAPTURE -> RELEASE and
// either back to SETUP (second identifier byte) or to IDLE. It loads
// the shared timer on entry to each wait phase.
// Assumes: T_CE_OE >= 1 and T_OE >= 1.
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int T_CE_OE = 3,
    parameter int T_OE    = 2,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             id_mode,
    input  logic             expired,
    output rd_state_t        state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             start,
    output logic             next_id,
    output logic             sample,
    output logic             id_active
);

    localparam logic [CNT_W-1:0] CE_RELOAD = CNT_W'(T_CE_OE - 1);
    localparam logic [CNT_W-1:0] OE_RELOAD = CNT_W'(T_OE - 1);

    rd_state_t state_q, state_d;
    logic      id_q, id_second_q;

    // Phase events used by the datapath.
    assign start   = (state_q == ST_IDLE) && req;
    assign next_id = (state_q == ST_RELEASE) && id_q && !id_second_q;
    assign sample  = (state_q == ST_OE_WAIT) && expired;

    // Next-phase and timer-load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CE_RELOAD;
        case (state_q)
            ST_IDLE:    if (req) state_d = ST_SETUP;
            ST_SETUP: begin
                state_d  = ST_CE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CE_RELOAD;
            end
            ST_CE_WAIT: if (expired) begin
                state_d  = ST_OE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = OE_RELOAD;
            end
            ST_OE_WAIT: if (expired) state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_RELEASE;
            ST_RELEASE: state_d = next_id ? ST_SETUP : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Identify-sequence flags: active for both reads, second marks byte 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q        <= 1'b0;
            id_second_q <= 1'b0;
        end else if (start) begin
            id_q        <= id_mode;
            id_second_q <= 1'b0;
        end else if (next_id) begin
            id_second_q <= 1'b1;
        end else if (state_q == ST_RELEASE) begin
            id_q        <= 1'b0;
            id_second_q <= 1'b0;
        end
    end

    assign state     = state_q;
    assign id_active = id_q;

    // R6: the release phase lasts a single cycle
    release_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE) |=> (state_q != ST_RELEASE));

    // R8: second-byte marker only inside an identify sequence
    id_second_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_second_q |-> id_q);

endmodule

// File: rtl/eprom_reader.sv
// Module: top of the EPROM read sequencer.
// Registers the memory address, decodes both strobes from the phase,
// captures the data lines and the identifier parity, and pulses ack.
// Assumes: T_CE_OE >= 1, T_OE >= 1; req is ignored outside idle.
module eprom_reader
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int T_CE_OE = 3,
    parameter int T_OE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_mode,
    output logic              ack,
    output logic [DATA_W-1:0] data,
    output logic              parity_err,
    output logic              id_mode_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);

    localparam int WAIT_MAX = (T_CE_OE > T_OE) ? T_CE_OE : T_OE;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    rd_state_t         state;
    logic              tmr_load, expired, start, next_id, sample, id_active;
    logic [CNT_W-1:0]  tmr_val;
    logic              odd_ok;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ack_q, perr_q;

    eprom_rd_seq #(.T_CE_OE(T_CE_OE), .T_OE(T_OE), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .id_mode(id_mode),
        .expired(expired), .state(state), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .start(start), .next_id(next_id),
        .sample(sample), .id_active(id_active)
    );

    eprom_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(expired)
    );

    eprom_id_parity #(.DATA_W(DATA_W)) u_par (
        .byte_in(mem_dq), .odd_ok(odd_ok)
    );

    // Address register: request address, or identifier index 0 then 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (start)   addr_q <= id_mode ? '0 : addr;
        else if (next_id) addr_q <= ADDR_W'(1);
    end

    // Capture register: byte, parity flag and ack pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            perr_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= sample;
            if (sample) begin
                data_q <= mem_dq;
                perr_q <= id_active && !odd_ok;
            end
        end
    end

    // Strobe decode from the registered phase.
    assign mem_ce_n    = !((state == ST_CE_WAIT) || (state == ST_OE_WAIT) ||
                           (state == ST_CAPTURE));
    assign mem_oe_n    = !((state == ST_OE_WAIT) || (state == ST_CAPTURE));
    assign mem_addr    = addr_q;
    assign data        = data_q;
    assign parity_err  = perr_q;
    assign ack         = ack_q;
    assign id_mode_req = id_active;

    // Cycle counters for the strobe-timing checks below.
    logic [15:0] ce_cyc, oe_cyc;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_cyc <= '0;
            oe_cyc <= '0;
        end else begin
            ce_cyc <= mem_ce_n ? 16'd0 : ce_cyc + 16'd1;
            oe_cyc <= mem_oe_n ? 16'd0 : oe_cyc + 16'd1;
        end
    end

    // R2
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R3
    oe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (ce_cyc == 16'(T_CE_OE)));

    // R4
    sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (!mem_oe_n && oe_cyc == 16'(T_OE - 1)));

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R8
    id_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode_req && !mem_ce_n) |-> (mem_addr[ADDR_W-1:1] == '0));

    // R9
    perr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !$past(id_mode_req)) |-> !parity_err);

endmodule

// File: tb/eprom_reader_test.sv
`timescale 1ns/1ps
module eprom_reader_test;

    localparam int ADDR_W  = 17;
    localparam int DATA_W  = 8;
    localparam int T_CE_OE = 3;
    localparam int T_OE    = 2;
    localparam logic [7:0] JUNK = 8'h5A;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              id_mode = 1'b0;
    logic              ack, parity_err, id_mode_req, mem_ce_n, mem_oe_n;
    logic [DATA_W-1:0] data, mem_dq;
    logic [ADDR_W-1:0] mem_addr;

    int errors = 0;
    int checks = 0;
    logic [7:0] mfr_code = 8'hC2;
    logic [7:0] dev_code = 8'h0E;

    always #4 clk = ~clk;

    eprom_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_CE_OE(T_CE_OE), .T_OE(T_OE)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .id_mode(id_mode),
        .ack(ack), .data(data), .parity_err(parity_err), .id_mode_req(id_mode_req),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    // Memory model: valid byte only after the full select and gate windows.
    int ce_low = 0, oe_low = 0;
    always @(posedge clk) begin
        ce_low <= mem_ce_n ? 0 : ce_low + 1;
        oe_low <= mem_oe_n ? 0 : oe_low + 1;
    end

    function automatic logic [7:0] mem_fn(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[16:9];
    endfunction

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && oe_low >= T_OE - 1 && ce_low >= T_CE_OE + T_OE - 1)
            mem_dq = id_mode_req ? (mem_addr[0] ? dev_code : mfr_code) : mem_fn(mem_addr);
        else
            mem_dq = JUNK;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Observe one read from the current negedge; off = index where ce falls.
    task automatic observe(input int off, input logic [ADDR_W-1:0] ea, input logic [7:0] ed,
                           input bit ep, input bit eid, input bit poke);
        int i_ce = -1, i_oe = -1, i_ack = -1;
        logic [ADDR_W-1:0] a_seen = '0;
        for (int i = 0; i < 64; i++) begin
            if (!mem_ce_n && i_ce < 0) begin i_ce = i; a_seen = mem_addr; end
            if (!mem_oe_n && i_oe < 0) i_oe = i;
            if (ack) begin i_ack = i; break; end
            check(!(i > 0 && mem_oe_n == 1'b0 && mem_ce_n == 1'b1), "R2 oe without ce", 1, 0);
            if (poke) begin
                req = (i == 2);
                addr = 17'h1F0F0;
            end
            @(negedge clk);
        end
        req = 1'b0;
        check(i_ce == off, "R3 ce fall index", i_ce, off);
        check(i_oe == off + T_CE_OE, "R3 oe fall index", i_oe, off + T_CE_OE);
        check(i_ack == off + T_CE_OE + T_OE, "R4 ack index", i_ack, off + T_CE_OE + T_OE);
        check(a_seen == ea, "R5/R8 address", a_seen, ea);
        check(data == ed, "R4 data", data, ed);
        check(parity_err == ep, "R9 parity_err", parity_err, ep);
        check(id_mode_req == eid, "R8 id_mode_req", id_mode_req, eid);
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && !ack, "R6 release", {mem_ce_n, mem_oe_n, ack}, 3'b110);
    endtask

    task automatic run(input bit id, input logic [ADDR_W-1:0] a, input bit poke);
        req = 1'b1; addr = a; id_mode = id;
        @(negedge clk);
        req = 1'b0; id_mode = 1'b0;
        if (!id) begin
            observe(1, a, mem_fn(a), 1'b0, 1'b0, poke);
        end else begin
            observe(1, '0, mfr_code, ~^mfr_code, 1'b1, 1'b0);
            check(id_mode_req, "R8 id held between reads", id_mode_req, 1);
            observe(2, 17'd1, dev_code, ~^dev_code, 1'b1, 1'b0);
        end
        @(negedge clk);
        check(!id_mode_req, "R8 id_mode_req drops", id_mode_req, 0);
    endtask

    // Stimulus table: {id_mode, addr}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 17'h00000}, {1'b0, 17'h12345}, {1'b1, 17'h1FFFF},
        {1'b0, 17'h0AAAA}, {1'b0, 17'h15555}, {1'b1, 17'h00000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_ce_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_oe_n}, 2'b11);
        check(!ack, "R1 ack low", ack, 0);
        check(mem_addr == '0, "R1 addr zero", mem_addr, 0);
        check(!id_mode_req, "R1 id_mode_req low", id_mode_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            run(VEC[k][17], VEC[k][16:0], 1'b0);
        end
        // R9 even-parity identifier bytes
        mfr_code = 8'hC3;
        dev_code = 8'h0F;
        run(1'b1, '0, 1'b0);
        mfr_code = 8'hC2;
        dev_code = 8'h0E;
        // R7 request during an access is ignored
        run(1'b0, 17'h00321, 1'b1);
        for (int k = 0; k < 4; k++) begin
            check(mem_ce_n && !ack, "R7 no extra access", {mem_ce_n, ack}, 2'b10);
            @(negedge clk);
        end
        // R1 reset again mid-idle after activity
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_addr == '0 && mem_ce_n, "R1 re-reset", mem_addr, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule